// File: doc/BRIEF.md
# Windowed MMIO Address Decoder

This block claims host memory accesses for a downstream bus. A fixed 256 MB region sits at the top of the 32-bit address space, starting at 0xF0000000. It is cut into 32 equal 8 MB slices. A 32-bit enable mask holds one bit per slice. An access whose address falls in an enabled slice is forwarded downstream, tagged with its slice number. Any other access is accepted and dropped.

Software can enable one slice, for example by writing the one-hot value `1 << i` after the slice is allocated. It can also enable several slices. Enabled slices that sit next to each other form one contiguous range. The block reports the lowest such run through a readback port: the first enabled slice, the run length in slices, and the run's start address.

Accesses arrive on a valid/ready stream. A hit passes straight through, so back-pressure from the downstream side stalls the host. A miss is consumed in the same cycle, whatever the downstream side is doing. The decode result is available combinationally. A registered copy, for timing, holds the decode of the most recently accepted access.

Top module: `mmio_window_decoder`

## Requirements
- R1: After reset, the enable mask is zero. No address hits, the registered hit flag and slice index are zero, and the run readback reports no enabled slice.
- R2: A cycle with `cfg_we_i` high loads `cfg_wdata_i` into the mask, and `en_mask_o` shows it from the next cycle. Without a write, the mask holds its value.
- R3: `hit_idx_o` always equals address bits 27:23. `hit_o` is high exactly when bits 31:28 equal 0xF and mask bit `hit_idx_o` is set.
- R4: An address whose bits 31:28 are not 0xF never hits, even with every mask bit set.
- R5: On a hit, `dn_valid_o` follows `up_valid_i` and `up_ready_o` follows `dn_ready_i`. On a miss, `dn_valid_o` is low and `up_ready_o` is high. `dn_addr_o` carries the address and `dn_win_o` carries the slice index.
- R6: One cycle after an accepted access (`up_valid_i` and `up_ready_o` both high), `hit_q_o` and `hit_idx_q_o` hold that access's hit flag and slice index. Otherwise they keep their values.
- R7: `any_en_o` is high exactly when the mask is nonzero. `run_first_o` is the lowest set mask bit. With a zero mask, `run_first_o`, `run_len_o` and `run_base_o` read zero.
- R8: `run_len_o` counts the consecutive set bits that start at `run_first_o`. `run_base_o` equals 0xF0000000 + `run_first_o` × 0x800000.
- R9: With a one-hot mask `1 << i`, only addresses in slice i hit, and `run_len_o` is 1.
- R10: With all 32 bits set, `run_len_o` is 32. Address 0xFFFFFFFF hits slice 31, 0xF0000000 hits slice 0, and 0xEFFFFFFF misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Enable-mask write strobe |
| cfg_wdata_i | input | 32 | New enable mask |
| en_mask_o | output | 32 | Current enable mask |
| up_valid_i | input | 1 | Host access valid |
| up_ready_o | output | 1 | Host access accepted |
| up_addr_i | input | 32 | Host access address |
| dn_valid_o | output | 1 | Downstream access valid (hits only) |
| dn_ready_i | input | 1 | Downstream ready |
| dn_addr_o | output | 32 | Forwarded address |
| dn_win_o | output | 5 | Slice index of the forwarded access |
| hit_o | output | 1 | Combinational hit flag for `up_addr_i` |
| hit_idx_o | output | 5 | Combinational slice index |
| hit_q_o | output | 1 | Registered hit flag of the last accepted access |
| hit_idx_q_o | output | 5 | Registered slice index of the last accepted access |
| any_en_o | output | 1 | Mask is nonzero |
| run_first_o | output | 5 | First enabled slice |
| run_len_o | output | 6 | Slices in the lowest contiguous run |
| run_base_o | output | 32 | Start address of the lowest run |

## Verification
Some results depend only on the current address and mask: the hit flag, the slice index and the stream handshake. These are checked mid-cycle, in the same cycle the address is driven. The mask readback and all run readback outputs change one cycle after the write edge. The registered hit copy is due one cycle after the accepting edge. The bench's reference model therefore updates its mask and registered copy at each rising edge, and compares every output at the following falling edge. Inputs change just after each rising edge, so each edge sees stable values.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  localparam int unsigned MWD_ADDR_W    = 32;
  localparam int unsigned MWD_NUM_WIN   = 32;
  localparam int unsigned MWD_WIN_SHIFT = 23;
  localparam int unsigned MWD_TAG_VAL   = 15;
endpackage

// File: rtl/mwd_enable_reg.sv
module mwd_enable_reg #(
  parameter int unsigned NUM_WIN = mwd_pkg::MWD_NUM_WIN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_WIN-1:0] wdata_i,
  output logic [NUM_WIN-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/mwd_slice_decode.sv
module mwd_slice_decode #(
  parameter int unsigned ADDR_W    = mwd_pkg::MWD_ADDR_W,
  parameter int unsigned NUM_WIN   = mwd_pkg::MWD_NUM_WIN,
  parameter int unsigned WIN_SHIFT = mwd_pkg::MWD_WIN_SHIFT,
  parameter int unsigned TAG_VAL   = mwd_pkg::MWD_TAG_VAL,
  localparam int unsigned IDX_W    = $clog2(NUM_WIN),
  localparam int unsigned TAG_W    = ADDR_W - IDX_W - WIN_SHIFT
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_WIN-1:0] mask_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic               tag_ok;
  logic [NUM_WIN-1:0] sel;

  assign idx_o  = addr_i[WIN_SHIFT +: IDX_W];
  assign tag_ok = (addr_i[ADDR_W-1 -: TAG_W] == TAG_W'(TAG_VAL));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_slice
    assign sel[w] = mask_i[w] && (idx_o == IDX_W'(w));
  end

  assign hit_o = tag_ok && (|sel);
endmodule

// File: rtl/mwd_run_finder.sv
module mwd_run_finder #(
  parameter int unsigned ADDR_W    = mwd_pkg::MWD_ADDR_W,
  parameter int unsigned NUM_WIN   = mwd_pkg::MWD_NUM_WIN,
  parameter int unsigned WIN_SHIFT = mwd_pkg::MWD_WIN_SHIFT,
  parameter int unsigned TAG_VAL   = mwd_pkg::MWD_TAG_VAL,
  localparam int unsigned IDX_W    = $clog2(NUM_WIN),
  localparam int unsigned LEN_W    = $clog2(NUM_WIN + 1),
  localparam int unsigned TAG_W    = ADDR_W - IDX_W - WIN_SHIFT
) (
  input  logic [NUM_WIN-1:0] mask_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   first_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [ADDR_W-1:0]  base_o
);
  logic found, ended;

  always_comb begin
    found   = 1'b0;
    ended   = 1'b0;
    first_o = '0;
    len_o   = '0;
    for (int w = 0; w < int'(NUM_WIN); w++) begin
      if (mask_i[w] && !ended) begin
        if (!found) first_o = IDX_W'(w);
        found = 1'b1;
        len_o = len_o + LEN_W'(1);
      end else if (found) begin
        ended = 1'b1;
      end
    end
  end

  assign any_o  = found;
  assign base_o = any_o ? {TAG_W'(TAG_VAL), first_o, {WIN_SHIFT{1'b0}}} : '0;
endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder #(
  parameter int unsigned ADDR_W    = mwd_pkg::MWD_ADDR_W,
  parameter int unsigned NUM_WIN   = mwd_pkg::MWD_NUM_WIN,
  parameter int unsigned WIN_SHIFT = mwd_pkg::MWD_WIN_SHIFT,
  parameter int unsigned TAG_VAL   = mwd_pkg::MWD_TAG_VAL,
  localparam int unsigned IDX_W    = $clog2(NUM_WIN),
  localparam int unsigned LEN_W    = $clog2(NUM_WIN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [NUM_WIN-1:0] cfg_wdata_i,
  output logic [NUM_WIN-1:0] en_mask_o,
  input  logic               up_valid_i,
  output logic               up_ready_o,
  input  logic [ADDR_W-1:0]  up_addr_i,
  output logic               dn_valid_o,
  input  logic               dn_ready_i,
  output logic [ADDR_W-1:0]  dn_addr_o,
  output logic [IDX_W-1:0]   dn_win_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic               hit_q_o,
  output logic [IDX_W-1:0]   hit_idx_q_o,
  output logic               any_en_o,
  output logic [IDX_W-1:0]   run_first_o,
  output logic [LEN_W-1:0]   run_len_o,
  output logic [ADDR_W-1:0]  run_base_o
);
  logic accept;

  mwd_enable_reg #(.NUM_WIN(NUM_WIN)) u_enable (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .mask_o (en_mask_o)
  );

  mwd_slice_decode #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_SHIFT(WIN_SHIFT), .TAG_VAL(TAG_VAL)
  ) u_decode (
    .addr_i(up_addr_i),
    .mask_i(en_mask_o),
    .hit_o (hit_o),
    .idx_o (hit_idx_o)
  );

  mwd_run_finder #(
    .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_SHIFT(WIN_SHIFT), .TAG_VAL(TAG_VAL)
  ) u_runs (
    .mask_i (en_mask_o),
    .any_o  (any_en_o),
    .first_o(run_first_o),
    .len_o  (run_len_o),
    .base_o (run_base_o)
  );

  // Hits stall on downstream back-pressure; misses are swallowed at once.
  assign dn_valid_o = up_valid_i && hit_o;
  assign up_ready_o = hit_o ? dn_ready_i : 1'b1;
  assign dn_addr_o  = up_addr_i;
  assign dn_win_o   = hit_idx_o;
  assign accept     = up_valid_i && up_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q_o     <= 1'b0;
      hit_idx_q_o <= '0;
    end else if (accept) begin
      hit_q_o     <= hit_o;
      hit_idx_q_o <= hit_idx_o;
    end
  end
endmodule

// File: rtl/mmio_window_decoder_chk.sv
module mmio_window_decoder_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned NUM_WIN = 32,
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned LEN_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [NUM_WIN-1:0] cfg_wdata_i,
  input logic [NUM_WIN-1:0] en_mask_o,
  input logic               up_valid_i,
  input logic               up_ready_o,
  input logic [ADDR_W-1:0]  up_addr_i,
  input logic               dn_valid_o,
  input logic               dn_ready_i,
  input logic               hit_o,
  input logic               hit_q_o,
  input logic [IDX_W-1:0]   hit_idx_q_o,
  input logic               any_en_o,
  input logic [IDX_W-1:0]   run_first_o,
  input logic [LEN_W-1:0]   run_len_o
);
  assert_mask_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (en_mask_o == $past(cfg_wdata_i)));
  assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(en_mask_o));
  assert_outside_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_addr_i[ADDR_W-1 -: 4] != 4'hF) |-> !hit_o);
  assert_dn_only_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> (up_valid_i && hit_o));
  assert_miss_consumed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && !hit_o) |-> up_ready_o);
  assert_hit_stall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_ready_i) |-> !up_ready_o);
  assert_copy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_valid_i && up_ready_o) |=> ($stable(hit_q_o) && $stable(hit_idx_q_o)));
  assert_copy_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_ready_o) |=> (hit_q_o == $past(hit_o)));
  assert_empty_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_mask_o == '0) |-> (!any_en_o && run_len_o == '0));
  assert_first_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en_o |-> (en_mask_o[run_first_o] && run_len_o != '0));
  assert_len_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len_o <= LEN_W'(NUM_WIN));
endmodule

bind mmio_window_decoder mmio_window_decoder_chk #(
  .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .LEN_W(LEN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .en_mask_o(en_mask_o), .up_valid_i(up_valid_i), .up_ready_o(up_ready_o),
  .up_addr_i(up_addr_i), .dn_valid_o(dn_valid_o), .dn_ready_i(dn_ready_i),
  .hit_o(hit_o), .hit_q_o(hit_q_o), .hit_idx_q_o(hit_idx_q_o),
  .any_en_o(any_en_o), .run_first_o(run_first_o), .run_len_o(run_len_o)
);

// File: tb/mmio_window_decoder_tb_top.sv
module mmio_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] en_mask;
  logic        up_valid = 1'b0;
  logic        up_ready;
  logic [31:0] up_addr = '0;
  logic        dn_valid;
  logic        dn_ready = 1'b0;
  logic [31:0] dn_addr;
  logic [4:0]  dn_win;
  logic        hit;
  logic [4:0]  hit_idx;
  logic        hit_q;
  logic [4:0]  hit_idx_q;
  logic        any_en;
  logic [4:0]  run_first;
  logic [5:0]  run_len;
  logic [31:0] run_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_mask = '0;
  bit          m_hq = 1'b0;
  int          m_iq = 0;

  always #2 clk = ~clk;

  mmio_window_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .en_mask_o(en_mask), .up_valid_i(up_valid), .up_ready_o(up_ready),
    .up_addr_i(up_addr), .dn_valid_o(dn_valid), .dn_ready_i(dn_ready),
    .dn_addr_o(dn_addr), .dn_win_o(dn_win), .hit_o(hit), .hit_idx_o(hit_idx),
    .hit_q_o(hit_q), .hit_idx_q_o(hit_idx_q), .any_en_o(any_en),
    .run_first_o(run_first), .run_len_o(run_len), .run_base_o(run_base)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [31:0] a, input logic [31:0] m);
    int slice = int'(a / 32'h0080_0000) % 32;
    return (a >= 32'hF000_0000) && m[slice];
  endfunction

  function automatic string hit_tag(input logic [31:0] a, input logic [31:0] m);
    if (a < 32'hF000_0000) return "R4";
    if (m == 32'hFFFF_FFFF) return "R10";
    if (m != 0 && (m & (m - 1)) == 0) return "R9";
    return "R3";
  endfunction

  // reference per-clock comparison, mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "mask in reset", en_mask, 0);
      chk("R1", "hit_q in reset", hit_q, 0);
      chk("R1", "any_en in reset", any_en, 0);
    end else if (!done) begin
      bit e_hit;
      int e_idx, e_first, e_len, w;
      e_hit = ref_hit(up_addr, m_mask);
      e_idx = int'(up_addr / 32'h0080_0000) % 32;
      chk("R2", "en_mask", en_mask, m_mask);
      chk(hit_tag(up_addr, m_mask), "hit", hit, e_hit);
      chk("R3", "hit_idx", hit_idx, e_idx);
      chk("R5", "dn_valid", dn_valid, up_valid && e_hit);
      chk("R5", "up_ready", up_ready, e_hit ? dn_ready : 1'b1);
      chk("R5", "dn_addr", dn_addr, up_addr);
      chk("R5", "dn_win", dn_win, e_idx);
      chk("R6", "hit_q", hit_q, m_hq);
      chk("R6", "hit_idx_q", hit_idx_q, m_iq);
      e_first = 0; e_len = 0; w = 0;
      while (w < 32 && !m_mask[w]) w++;
      if (w < 32) begin
        e_first = w;
        while (w < 32 && m_mask[w]) begin e_len++; w++; end
      end
      chk("R7", "any_en", any_en, m_mask != 0);
      chk("R7", "run_first", run_first, e_first);
      chk(m_mask == 32'hFFFF_FFFF ? "R10" : (e_len == 1 ? "R9" : "R8"), "run_len", run_len, e_len);
      chk("R8", "run_base", run_base, (m_mask == 0) ? 0 : 64'hF000_0000 + e_first * 64'h80_0000);
    end
  end

  // reference update at the edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask <= '0; m_hq <= 1'b0; m_iq <= 0;
    end else begin
      bit h;
      h = ref_hit(up_addr, m_mask);
      if (up_valid && (h ? dn_ready : 1'b1)) begin
        m_hq <= h;
        m_iq <= int'(up_addr / 32'h0080_0000) % 32;
      end
      if (cfg_we) m_mask <= cfg_wdata;
    end
  end

  task automatic step(input bit we, input logic [31:0] wd, input bit v,
                      input logic [31:0] a, input bit rdy);
    @(posedge clk); #1;
    cfg_we = we; cfg_wdata = wd; up_valid = v; up_addr = a; dn_ready = rdy;
  endtask

  function automatic logic [31:0] in_region();
    return 32'hF000_0000 | ($urandom & 32'h0FFF_FFFF);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: no hits before any enable
    for (int k = 0; k < 20; k++) step(0, 0, 1, in_region(), 1);
    // R10 / R4: all slices on, edges of the region
    step(1, 32'hFFFF_FFFF, 0, 0, 1);
    step(0, 0, 1, 32'hFFFF_FFFF, 1);
    step(0, 0, 1, 32'hF000_0000, 0);
    step(0, 0, 1, 32'hEFFF_FFFF, 0);
    step(0, 0, 1, 32'h0000_0000, 1);
    step(0, 0, 1, 32'h7F80_0000, 1);
    // R9: one-hot masks, hit own slice, miss neighbour
    for (int i = 0; i < 32; i++) begin
      step(1, 32'd1 << i, 0, 0, 1);
      step(0, 0, 1, 32'hF000_0000 + i * 32'h0080_0000 + ($urandom & 32'h7F_FFFF), 1);
      step(0, 0, 1, 32'hF000_0000 + ((i + 1) % 32) * 32'h0080_0000, 1);
    end
    // R8: contiguous runs plus stray bits
    step(1, 32'h8000_0F38, 1, in_region(), 1);
    step(0, 0, 1, 32'hF180_0000, 0);
    step(0, 0, 1, 32'hF180_0000, 1);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      bit we = ($urandom % 16) == 0;
      logic [31:0] wd;
      case ($urandom % 4)
        0: wd = $urandom;
        1: wd = 32'd1 << ($urandom % 32);
        2: wd = ((32'd1 << ($urandom % 8)) - 1) << ($urandom % 24);
        default: wd = $urandom & $urandom;
      endcase
      step(we, wd, ($urandom % 4) != 0, (($urandom % 5) < 3) ? in_region() : $urandom,
           ($urandom % 2) == 1);
    end
    // R7: clear mask
    step(1, 0, 1, in_region(), 1);
    step(0, 0, 1, in_region(), 1);
    step(0, 0, 0, 0, 1);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule